// File: doc/BRIEF.md
# Interleaved Image Header Parser

This block takes in a byte stream holding several configuration images packed together in fixed-size chunks. Chunks are handed to the images in turn, so chunk 0 goes to image 1, chunk 1 to image 2, and so on until the rotation wraps. A start pulse latches a 1-based image selector and begins a run. From then on, every byte that belongs to another image is accepted and thrown away. The bytes of the selected image go to a header parser.

The parser first checks that the selected image opens with a fixed 13-byte preamble. It then reads tagged sections. Each section has a one-byte letter tag, a big-endian length and that many content bytes. Sections that carry no payload are skipped. When the payload section turns up, the block pulses a strobe with its 32-bit length and then forwards the payload bytes on an output stream with a valid/ready handshake. The run ends as soon as the last payload byte has left. A failed run stops with an error code on a status output instead. Decompressing the archive and programming the target device are both handled outside this block.

Top module: `imgp_stream_parser`

## Requirements
- R1: A start pulse latches `img_sel` and begins a run. A selector of 0 or above `NUM_IMG` ends the run at once with error code 5. Outside a run, `in_ready` is low and `busy` is low.
- R2: Counting from 0 at the start of a run, accepted byte i belongs to image ((i / CHUNK_LEN) mod NUM_IMG) + 1. Bytes of the other images are accepted and dropped, and they never reach the parser or the output.
- R3: The selected image must begin with 00 09 0F F0 0F F0 0F F0 0F F0 00 00 01. The first byte that differs ends the run with error code 1.
- R4: A section tag byte outside ASCII 'a' (0x61) to 'e' (0x65) ends the run with error code 2.
- R5: Tags 'a' to 'd' are followed by a 2-byte length and tag 'e' by a 4-byte length, each sent most significant byte first. The content of sections 'a' to 'd' is skipped.
- R6: A section other than 'e' whose length is above 255 ends the run with error code 3.
- R7: Tag, length and skipped content bytes after the preamble count as header bytes. If a tag byte or a skipped content byte is needed after 100 header bytes have already been taken, the run ends with error code 4 and that byte is not consumed. Length bytes are always read.
- R8: In the cycle after the last length byte of section 'e' is accepted, `found` is high for exactly one cycle and `payload_len` shows the 32-bit length. `payload_len` holds that value until the next `found`.
- R9: The `payload_len` bytes that follow the 'e' length go out on `out_data` in order. `done` is raised after the last of them. A zero length raises `done` in the same cycle as `found`. Error code 0 means no error.
- R10: No byte is counted or consumed unless `in_valid` and `in_ready` are both high. While a payload byte of the selected image is waiting, `in_ready` follows `out_ready`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a run and latch the selector |
| img_sel | input | $clog2(NUM_IMG+1) | 1-based image to extract |
| in_data | input | 8 | Archive byte |
| in_valid | input | 1 | Archive byte present |
| in_ready | output | 1 | Archive byte taken this cycle when valid |
| out_data | output | 8 | Payload byte |
| out_valid | output | 1 | Payload byte present |
| out_ready | input | 1 | Downstream takes the payload byte |
| busy | output | 1 | A run is in progress |
| done | output | 1 | Payload fully delivered |
| err_code | output | 3 | 0 none, 1 preamble, 2 tag, 3 length, 4 search limit, 5 selector |
| found | output | 1 | One-cycle strobe when the payload length is known |
| payload_len | output | 32 | Length of the payload section |

## Verification
Two things can happen in the same cycle: the chunk rotation moves ownership to another image, and the parser changes state. Examples are the last 'e' length byte landing on the final byte of a chunk, or a payload byte stalled by `out_ready` while the next byte belongs to a foreign chunk. A directed image puts the 'e' length end exactly on a chunk boundary. Randomly built images, random valid gaps and random output stalls create the other collisions. Each run is judged against a bench model that derives each byte's owner arithmetically and re-parses the selected image to predict the error code, the strobe count, the length and the exact payload bytes.

// File: rtl/imgp_pkg.sv
package imgp_pkg;

  typedef enum logic [2:0] {
    ST_IDLE, ST_PRE, ST_TAG, ST_LEN, ST_SKIP, ST_PAY, ST_DONE, ST_ERR
  } parse_st_t;

  typedef enum logic [2:0] {
    ERR_NONE     = 3'd0,
    ERR_PREAMBLE = 3'd1,
    ERR_TAG      = 3'd2,
    ERR_LENGTH   = 3'd3,
    ERR_LIMIT    = 3'd4,
    ERR_SELECT   = 3'd5
  } err_t;

  localparam int PRE_LEN = 13;
  localparam logic [7:0] TAG_FIRST   = 8'h61;
  localparam logic [7:0] TAG_PAYLOAD = 8'h65;

  // Expected preamble byte at position idx.
  function automatic logic [7:0] preamble_byte(input logic [3:0] idx);
    logic [7:0] b;
    if (idx == 4'd0 || idx == 4'd10 || idx == 4'd11) b = 8'h00;
    else if (idx == 4'd1)  b = 8'h09;
    else if (idx == 4'd12) b = 8'h01;
    else if (idx[0] == 1'b0) b = 8'h0F;
    else b = 8'hF0;
    return b;
  endfunction

  function automatic logic tag_legal(input logic [7:0] t);
    return (t >= TAG_FIRST) && (t <= TAG_PAYLOAD);
  endfunction

  // Number of length bytes that follow a tag.
  function automatic logic [2:0] len_bytes(input logic [7:0] t);
    return (t == TAG_PAYLOAD) ? 3'd4 : 3'd2;
  endfunction

endpackage

// File: rtl/imgp_chunk_filter.sv
module imgp_chunk_filter #(
  parameter int CHUNK_LEN = 288,
  parameter int NUM_IMG   = 4,
  localparam int OFS_W    = $clog2(CHUNK_LEN),
  localparam int IMG_W    = $clog2(NUM_IMG + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             restart,
  input  logic             step,
  input  logic [IMG_W-1:0] sel_idx,
  output logic             own,
  output logic             chunk_last
);

  logic [OFS_W-1:0] ofs_q;
  logic [IMG_W-1:0] owner_q;

  assign chunk_last = (ofs_q == OFS_W'(CHUNK_LEN - 1));
  assign own        = (owner_q == sel_idx);

  always_ff @(posedge clk) begin
    if (!rst_n || restart) begin
      ofs_q   <= '0;
      owner_q <= '0;
    end else if (step) begin
      if (chunk_last) begin
        ofs_q   <= '0;
        owner_q <= (owner_q == IMG_W'(NUM_IMG - 1)) ? '0 : owner_q + 1'b1;
      end else begin
        ofs_q <= ofs_q + 1'b1;
      end
    end
  end

endmodule

// File: rtl/imgp_payload_counter.sv
module imgp_payload_counter #(
  parameter int LEN_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             restart,
  input  logic             load,
  input  logic [LEN_W-1:0] load_val,
  input  logic             dec,
  output logic             last
);

  logic [LEN_W-1:0] left_q;

  assign last = (left_q == LEN_W'(1));

  always_ff @(posedge clk) begin
    if (!rst_n || restart) left_q <= '0;
    else if (load)         left_q <= load_val;
    else if (dec)          left_q <= left_q - 1'b1;
  end

endmodule

// File: rtl/imgp_section_parser.sv
module imgp_section_parser
  import imgp_pkg::*;
#(
  parameter int SEARCH_LIMIT = 100,
  localparam int HW          = $clog2(SEARCH_LIMIT + 8)
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start,
  input  logic        sel_bad,
  input  logic        own,
  input  logic        in_valid,
  input  logic [7:0]  in_data,
  input  logic        out_ready,
  input  logic        pay_last,
  output logic        in_ready,
  output logic        out_valid,
  output logic        accept,
  output logic        pay_load,
  output logic        pay_step,
  output logic [31:0] len_word,
  output parse_st_t   state,
  output err_t        err,
  output logic        found,
  output logic [31:0] payload_len
);

  parse_st_t   st_q;
  err_t        err_q;
  logic [3:0]  pre_idx_q;
  logic [7:0]  tag_q;
  logic [31:0] len_acc_q;
  logic [2:0]  len_cnt_q;
  logic [7:0]  skip_left_q;
  logic [HW-1:0] hdr_cnt_q;
  logic        found_q;
  logic [31:0] plen_q;

  logic lim_hit;
  logic active;
  logic take;
  logic len_final;

  assign state       = st_q;
  assign err         = err_q;
  assign found       = found_q;
  assign payload_len = plen_q;

  assign lim_hit = ((st_q == ST_TAG) || (st_q == ST_SKIP)) &&
                   (hdr_cnt_q >= HW'(SEARCH_LIMIT));
  assign active  = (st_q == ST_PRE) || (st_q == ST_TAG) || (st_q == ST_LEN) ||
                   (st_q == ST_SKIP) || (st_q == ST_PAY);

  assign in_ready  = !start && active && !lim_hit &&
                     (!own || (st_q != ST_PAY) || out_ready);
  assign out_valid = !start && (st_q == ST_PAY) && own && in_valid;
  assign accept    = in_valid && in_ready;
  assign take      = accept && own;
  assign len_word  = {len_acc_q[23:0], in_data};
  assign len_final = (len_cnt_q == 3'd1);
  assign pay_load  = take && (st_q == ST_LEN) && len_final && (tag_q == TAG_PAYLOAD);
  assign pay_step  = take && (st_q == ST_PAY);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q        <= ST_IDLE;
      err_q       <= ERR_NONE;
      pre_idx_q   <= '0;
      tag_q       <= '0;
      len_acc_q   <= '0;
      len_cnt_q   <= '0;
      skip_left_q <= '0;
      hdr_cnt_q   <= '0;
      found_q     <= 1'b0;
      plen_q      <= '0;
    end else begin
      found_q <= 1'b0;
      if (start) begin
        st_q      <= sel_bad ? ST_ERR : ST_PRE;
        err_q     <= sel_bad ? ERR_SELECT : ERR_NONE;
        pre_idx_q <= '0;
        hdr_cnt_q <= '0;
        len_acc_q <= '0;
      end else if (lim_hit) begin
        st_q  <= ST_ERR;
        err_q <= ERR_LIMIT;
      end else if (take) begin
        unique case (st_q)
          ST_PRE: begin
            pre_idx_q <= pre_idx_q + 1'b1;
            if (in_data != preamble_byte(pre_idx_q)) begin
              st_q  <= ST_ERR;
              err_q <= ERR_PREAMBLE;
            end else if (pre_idx_q == 4'(PRE_LEN - 1)) begin
              st_q <= ST_TAG;
            end
          end
          ST_TAG: begin
            hdr_cnt_q <= hdr_cnt_q + 1'b1;
            if (!tag_legal(in_data)) begin
              st_q  <= ST_ERR;
              err_q <= ERR_TAG;
            end else begin
              tag_q     <= in_data;
              len_cnt_q <= len_bytes(in_data);
              len_acc_q <= '0;
              st_q      <= ST_LEN;
            end
          end
          ST_LEN: begin
            hdr_cnt_q <= hdr_cnt_q + 1'b1;
            len_acc_q <= len_word;
            len_cnt_q <= len_cnt_q - 1'b1;
            if (len_final) begin
              if (tag_q == TAG_PAYLOAD) begin
                found_q <= 1'b1;
                plen_q  <= len_word;
                st_q    <= (len_word == 32'd0) ? ST_DONE : ST_PAY;
              end else if (len_word > 32'd255) begin
                st_q  <= ST_ERR;
                err_q <= ERR_LENGTH;
              end else if (len_word == 32'd0) begin
                st_q <= ST_TAG;
              end else begin
                skip_left_q <= len_word[7:0];
                st_q        <= ST_SKIP;
              end
            end
          end
          ST_SKIP: begin
            hdr_cnt_q   <= hdr_cnt_q + 1'b1;
            skip_left_q <= skip_left_q - 1'b1;
            if (skip_left_q == 8'd1) st_q <= ST_TAG;
          end
          ST_PAY: begin
            if (pay_last) st_q <= ST_DONE;
          end
          default: ;
        endcase
      end
    end
  end

endmodule

// File: rtl/imgp_stream_parser.sv
module imgp_stream_parser
  import imgp_pkg::*;
#(
  parameter int CHUNK_LEN    = 288,
  parameter int NUM_IMG      = 4,
  parameter int SEARCH_LIMIT = 100,
  localparam int IMG_W       = $clog2(NUM_IMG + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [IMG_W-1:0] img_sel,
  input  logic [7:0]       in_data,
  input  logic             in_valid,
  output logic             in_ready,
  output logic [7:0]       out_data,
  output logic             out_valid,
  input  logic             out_ready,
  output logic             busy,
  output logic             done,
  output logic [2:0]       err_code,
  output logic             found,
  output logic [31:0]      payload_len
);

  logic [IMG_W-1:0] sel_idx_q;
  logic             sel_bad;
  logic             own_byte;
  logic             chunk_last;
  logic             accept;
  logic             pay_load;
  logic             pay_step;
  logic             pay_last;
  logic [31:0]      len_word;
  parse_st_t        state;
  err_t             err;

  assign sel_bad = (img_sel == '0) || (img_sel > IMG_W'(NUM_IMG));

  always_ff @(posedge clk) begin
    if (!rst_n)     sel_idx_q <= '0;
    else if (start) sel_idx_q <= img_sel - 1'b1;
  end

  imgp_chunk_filter #(
    .CHUNK_LEN (CHUNK_LEN),
    .NUM_IMG   (NUM_IMG)
  ) u_filter (
    .clk        (clk),
    .rst_n      (rst_n),
    .restart    (start),
    .step       (accept),
    .sel_idx    (sel_idx_q),
    .own        (own_byte),
    .chunk_last (chunk_last)
  );

  imgp_payload_counter #(
    .LEN_W (32)
  ) u_paycnt (
    .clk      (clk),
    .rst_n    (rst_n),
    .restart  (start),
    .load     (pay_load),
    .load_val (len_word),
    .dec      (pay_step),
    .last     (pay_last)
  );

  imgp_section_parser #(
    .SEARCH_LIMIT (SEARCH_LIMIT)
  ) u_parser (
    .clk         (clk),
    .rst_n       (rst_n),
    .start       (start),
    .sel_bad     (sel_bad),
    .own         (own_byte),
    .in_valid    (in_valid),
    .in_data     (in_data),
    .out_ready   (out_ready),
    .pay_last    (pay_last),
    .in_ready    (in_ready),
    .out_valid   (out_valid),
    .accept      (accept),
    .pay_load    (pay_load),
    .pay_step    (pay_step),
    .len_word    (len_word),
    .state       (state),
    .err         (err),
    .found       (found),
    .payload_len (payload_len)
  );

  assign out_data = in_data;
  assign busy     = (state == ST_PRE) || (state == ST_TAG) || (state == ST_LEN) ||
                    (state == ST_SKIP) || (state == ST_PAY);
  assign done     = (state == ST_DONE);
  assign err_code = err;

endmodule

// File: rtl/imgp_checker.sv
module imgp_checker (
  input logic        clk,
  input logic        rst_n,
  input logic        in_valid,
  input logic        in_ready,
  input logic        out_valid,
  input logic        out_ready,
  input logic        own_byte,
  input logic        busy,
  input logic        done,
  input logic [2:0]  err_code,
  input logic        found,
  input logic [31:0] payload_len
);

  a_r1_idle_not_ready: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !in_ready);

  a_r10_out_needs_in: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> in_valid);

  a_r10_out_take_consumes: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_ready) |-> in_ready);

  a_r2_foreign_not_forwarded: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready && !own_byte) |-> !out_valid);

  a_r8_found_single: assert property (@(posedge clk) disable iff (!rst_n)
    found |=> !found);

  a_r8_len_held: assert property (@(posedge clk) disable iff (!rst_n)
    !found |-> $stable(payload_len));

  a_r3_error_ends_run: assert property (@(posedge clk) disable iff (!rst_n)
    (err_code != 3'd0) |-> !busy);

  a_r9_done_clean: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (err_code == 3'd0 && !busy));

endmodule

bind imgp_stream_parser imgp_checker u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .in_valid    (in_valid),
  .in_ready    (in_ready),
  .out_valid   (out_valid),
  .out_ready   (out_ready),
  .own_byte    (own_byte),
  .busy        (busy),
  .done        (done),
  .err_code    (err_code),
  .found       (found),
  .payload_len (payload_len)
);

// File: tb/tb_imgp_stream_parser.sv
module tb_imgp_stream_parser;

  localparam int CLK_PERIOD = 10;
  localparam int CHUNK = 20;
  localparam int NIMG  = 5;
  localparam int LIMIT = 100;
  localparam int SW    = $clog2(NIMG + 1);
  localparam int ISZ   = 256;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic [SW-1:0] img_sel = '0;
  logic [7:0] in_data = '0;
  logic in_valid = 1'b0;
  logic in_ready;
  logic [7:0] out_data;
  logic out_valid;
  logic out_ready = 1'b0;
  logic busy, done, found;
  logic [2:0] err_code;
  logic [31:0] payload_len;

  always #(CLK_PERIOD/2) clk = ~clk;

  imgp_stream_parser #(.CHUNK_LEN(CHUNK), .NUM_IMG(NIMG), .SEARCH_LIMIT(LIMIT)) dut (
    .clk(clk), .rst_n(rst_n), .start(start), .img_sel(img_sel),
    .in_data(in_data), .in_valid(in_valid), .in_ready(in_ready),
    .out_data(out_data), .out_valid(out_valid), .out_ready(out_ready),
    .busy(busy), .done(done), .err_code(err_code), .found(found),
    .payload_len(payload_len));

  int n_checks = 0;
  int n_fail = 0;

  logic [7:0] img_mem [NIMG][ISZ];
  int wp;
  int cur;

  int exp_err, exp_found, exp_ps;
  logic [31:0] exp_len;
  logic [7:0] got_pay [64];
  int got_cnt, got_found;

  task automatic check(input bit ok, input string req, input longint got, input longint exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: got %0d expected %0d", req, got, exp);
    end
  endtask

  function automatic logic [7:0] pre_ref(input int i);
    logic [7:0] t [13] = '{8'h00, 8'h09, 8'h0F, 8'hF0, 8'h0F, 8'hF0, 8'h0F,
                           8'hF0, 8'h0F, 8'hF0, 8'h00, 8'h00, 8'h01};
    return t[i];
  endfunction

  function automatic logic [7:0] rd(input int k, input int p);
    return (p < ISZ) ? img_mem[k][p] : 8'hAA;
  endfunction

  // Owner of stream byte i is image (i/CHUNK) mod NIMG (0-based here).
  function automatic logic [7:0] stream_byte(input int i);
    int rnd, rem, own, pos;
    rnd = i / (CHUNK * NIMG);
    rem = i % (CHUNK * NIMG);
    own = rem / CHUNK;
    pos = rnd * CHUNK + rem % CHUNK;
    return rd(own, pos);
  endfunction

  task automatic fill_all();
    for (int k = 0; k < NIMG; k++)
      for (int p = 0; p < ISZ; p++) img_mem[k][p] = 8'($urandom);
  endtask

  task automatic begin_img(input int k);
    cur = k;
    for (int p = 0; p < 13; p++) img_mem[k][p] = pre_ref(p);
    wp = 13;
  endtask

  task automatic put(input logic [7:0] b);
    if (wp < ISZ) img_mem[cur][wp] = b;
    wp++;
  endtask

  task automatic add_sec(input logic [7:0] tag, input int len);
    put(tag);
    if (tag == 8'h65) begin
      put(8'(len >> 24)); put(8'(len >> 16));
    end
    put(8'(len >> 8)); put(8'(len));
    for (int j = 0; j < len && wp < ISZ; j++) put(8'($urandom));
  endtask

  // Independent re-parse of the selected image.
  task automatic model(input int k);
    int pos, hdr, n;
    logic [7:0] t;
    logic [31:0] L;
    exp_found = 0; exp_len = 0; exp_ps = 0;
    for (int i = 0; i < 13; i++)
      if (img_mem[k][i] != pre_ref(i)) begin exp_err = 1; return; end
    pos = 13; hdr = 0;
    while (1) begin
      if (hdr >= LIMIT) begin exp_err = 4; return; end
      t = rd(k, pos); pos++; hdr++;
      if (t < 8'h61 || t > 8'h65) begin exp_err = 2; return; end
      n = (t == 8'h65) ? 4 : 2;
      L = 0;
      for (int j = 0; j < n; j++) begin L = {L[23:0], rd(k, pos)}; pos++; end
      hdr += n;
      if (t == 8'h65) begin
        exp_found = 1; exp_len = L; exp_ps = pos; exp_err = 0; return;
      end
      if (L > 255) begin exp_err = 3; return; end
      for (int j = 0; j < int'(L); j++) begin
        if (hdr >= LIMIT) begin exp_err = 4; return; end
        pos++; hdr++;
      end
    end
  endtask

  task automatic run_case(input int sel, input string req);
    int idx, cyc;
    bit fin;
    int exp_n;
    if (sel >= 1 && sel <= NIMG) model(sel - 1);
    else begin exp_err = 5; exp_found = 0; exp_len = 0; end
    got_cnt = 0; got_found = 0; idx = 0; cyc = 0; fin = 0;
    @(negedge clk);
    start = 1'b1; img_sel = SW'(sel); in_valid = 1'b0;
    @(negedge clk);
    start = 1'b0;
    #1;
    while (!fin && cyc < 6000) begin
      if (found) got_found++;
      if (!busy) fin = 1;
      else begin
        @(negedge clk);
        cyc++;
        in_valid  = ($urandom % 5) != 0;
        in_data   = stream_byte(idx);
        out_ready = ($urandom % 10) < 7;
        #1;
        if (in_valid && in_ready) idx++;
        if (out_valid && out_ready) begin
          if (got_cnt < 64) got_pay[got_cnt] = out_data;
          got_cnt++;
        end
      end
    end
    in_valid = 1'b0;
    check(fin, {req, " run ends"}, cyc, 6000);
    check(err_code == 3'(exp_err), {req, " err_code"}, err_code, exp_err);
    check(done == (exp_err == 0), {req, " R9 done"}, done, exp_err == 0);
    check(got_found == exp_found, {req, " R8 found strobes"}, got_found, exp_found);
    if (exp_found != 0)
      check(payload_len == exp_len, {req, " R8 R5 payload_len"}, payload_len, exp_len);
    exp_n = (exp_err == 0) ? int'(exp_len) : 0;
    check(got_cnt == exp_n, {req, " R9 payload count"}, got_cnt, exp_n);
    begin
      int bad;
      bad = 0;
      for (int j = 0; j < got_cnt && j < 64; j++)
        if (got_pay[j] != rd(sel - 1, exp_ps + j)) bad++;
      check(bad == 0, {req, " R2 R9 payload bytes"}, bad, 0);
    end
  endtask

  initial begin
    #(CLK_PERIOD * 190000);
    n_checks++; n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    int seed_init;
    seed_init = $urandom(32'h5EED);
    repeat (3) @(negedge clk);
    // R1 reset state
    in_valid = 1'b1;
    #1;
    check(!busy && !in_ready && !done && !found && err_code == 0 && payload_len == 0 && !out_valid,
          "R1 reset state", {busy, in_ready, done, found}, 0);
    in_valid = 1'b0;
    rst_n = 1'b1;
    @(negedge clk);

    // R5 R2: several skipped sections then payload, image 2
    fill_all(); begin_img(1);
    add_sec(8'h61, 4); add_sec(8'h62, 0); add_sec(8'h63, 7); add_sec(8'h64, 2);
    add_sec(8'h65, 30);
    run_case(2, "R5 R2 basic");

    // R2 chunk boundary: last 'e' length byte at the last byte of a chunk
    fill_all(); begin_img(4);
    add_sec(8'h61, 19); add_sec(8'h65, 25);
    run_case(5, "R2 chunk edge");

    // R3 preamble mismatch at byte 5
    fill_all(); begin_img(0); img_mem[0][5] = 8'h0F;
    run_case(1, "R3 preamble");

    // R4 illegal tag
    fill_all(); begin_img(2); add_sec(8'h61, 3); put(8'h66);
    run_case(3, "R4 bad tag");
    fill_all(); begin_img(2); put(8'h60);
    run_case(3, "R4 low tag");

    // R6 oversize non-payload section
    fill_all(); begin_img(3); add_sec(8'h62, 300);
    run_case(4, "R6 long section");

    // R7 search limit: length bytes pushed past 100, then a skip byte is needed
    fill_all(); begin_img(1); add_sec(8'h61, 95); add_sec(8'h62, 5);
    run_case(2, "R7 limit in skip");
    // R7 exactly 100 header bytes, then a tag is needed
    fill_all(); begin_img(1); add_sec(8'h61, 97); add_sec(8'h65, 4);
    run_case(2, "R7 limit at tag");
    // R7 tag at header byte 99 is still read
    fill_all(); begin_img(1); add_sec(8'h61, 96); add_sec(8'h65, 6);
    run_case(2, "R7 last tag ok");

    // R9 zero-length payload
    fill_all(); begin_img(0); add_sec(8'h65, 0);
    run_case(1, "R9 zero payload");

    // R1 invalid selectors
    run_case(0, "R1 sel zero");
    run_case(7, "R1 sel high");

    // R10 random images with random gaps and stalls
    for (int r = 0; r < 8; r++) begin
      int k, ns;
      k = int'($urandom % NIMG);
      fill_all(); begin_img(k);
      ns = int'($urandom % 5);
      for (int s = 0; s < ns; s++) add_sec(8'(8'h61 + ($urandom % 4)), int'($urandom % 21));
      add_sec(8'h65, 1 + int'($urandom % 40));
      run_case(k + 1, "R10 random");
    end

    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

endmodule